// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block is the register front end of an on-chip analog-to-digital converter. A CPU reaches it through a small synchronous bus with separate read and write strobes. Through the bus it sets up the converter: reference source, channel and result alignment. It also enables the converter, chooses the clock divider, starts conversions, allows a trigger input to start them, and enables an interrupt on completion. A separate conversion sequencer receives a one-cycle start pulse. When it finishes, it returns a done pulse together with a 10-bit result.

The 10-bit result is read as two bytes. The alignment setting decides how the ten bits are spread across the two bytes. It is applied when the bytes are read, so a changed setting re-formats the result that is already stored. Reading the low byte freezes the high byte until the high byte has been read. A later result can therefore never mix with the half already read. The completion flag is set by hardware and cleared by software writing a one to it. The start bit clears itself when the conversion ends.

Top module: `cnv_regs`

## Requirements
- R1: After reset, all four register addresses read 0x00, `irq` is 0 and `seq_start` is 0.
- R2: Address 0 is the setup register. Bits 7:6 select the reference: 00 external, 01 supply, 10 reserved, 11 internal. Bit 5 is left alignment. Bits 3:0 are the channel, with codes 0 to 7 valid. Bit 4 reads 0. The fields drive `ref_sel` and `chan_sel`.
- R3: Address 1 is the control register. Writing it with bit 7 (enable) = 1 and bit 6 (start) = 1 while idle pulses `seq_start` for one cycle. Bit 6 then reads 1 until `seq_done` arrives, and reads 0 after that.
- R4: Control bit 4 is the completion flag. It is set when a running conversion ends. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R5: `irq` is high whenever control bit 3 (interrupt enable) and the completion flag are both 1.
- R6: A write with start = 1 and enable = 0 starts nothing. A write with start = 0 during a conversion does not stop it.
- R7: With right alignment, address 2 returns result bits 7:0 and address 3 returns bits 9:8 in its bits 1:0, with zeros above.
- R8: With left alignment, address 3 returns result bits 9:2 and address 2 returns bits 1:0 in its bits 7:6, with zeros below.
- R9: A read of address 2 locks the data registers until address 3 is read. A result that ends while they are locked is discarded, and the flag is still set.
- R10: If a conversion ends in the same cycle as a write that clears the flag, the flag ends up set.
- R11: With control bit 5 (auto-trigger) = 1 and enable = 1, a high `trig_in` while idle starts a conversion. With auto-trigger = 0, `trig_in` is ignored.
- R12: A result that ends in the same cycle as a read of address 2 is discarded. The byte pair that is read stays consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on addresses 2 and 3) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| trig_in | input | 1 | Trigger event for auto-triggered starts |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_done | input | 1 | Conversion end pulse from the sequencer |
| seq_result | input | 10 | Result, valid with seq_done |
| ref_sel | output | 2 | Reference select |
| chan_sel | output | 4 | Channel select |
| div_sel | output | 3 | Clock divider select |
| conv_en | output | 1 | Converter enable |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are provoked on purpose. In the first, the sequencer's done pulse lands in the same cycle as a software write that clears the flag, and the status read that follows must show the flag set. In the second, the done pulse lands in the same cycle as a low-byte read. The bench then reads the high byte and the low byte again, and both must still belong to the earlier result, which shows the new result was dropped rather than torn across the two bytes.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  localparam int RES_W = 10;
  localparam int DW    = 8;
  localparam int AW    = 2;
  localparam int SH    = 2 * DW - RES_W;
  localparam int LOW_W = RES_W - DW;

  localparam logic [AW-1:0] A_SETUP = 2'd0;
  localparam logic [AW-1:0] A_CTRL  = 2'd1;
  localparam logic [AW-1:0] A_LO    = 2'd2;
  localparam logic [AW-1:0] A_HI    = 2'd3;

  localparam int B_EN   = 7;
  localparam int B_GO   = 6;
  localparam int B_AUTO = 5;
  localparam int B_FLAG = 4;
  localparam int B_IE   = 3;

  function automatic logic [DW-1:0] fmt_lo(input logic [RES_W-1:0] r, input logic left);
    if (left) return {r[LOW_W-1:0], {(DW-LOW_W){1'b0}}};
    return r[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] fmt_hi(input logic [RES_W-1:0] r, input logic left);
    if (left) return r[RES_W-1:RES_W-DW];
    return {{SH{1'b0}}, r[RES_W-1:DW]};
  endfunction
endpackage

// File: rtl/cnv_setup_reg.sv
module cnv_setup_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] ref_in,
  input  logic       left_in,
  input  logic [3:0] chan_in,
  output logic [1:0] ref_sel,
  output logic       left_adj,
  output logic [3:0] chan_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel  <= '0;
      left_adj <= 1'b0;
      chan_sel <= '0;
    end else if (wr_en) begin
      ref_sel  <= ref_in;
      left_adj <= left_in;
      chan_sel <= chan_in;
    end
  end
endmodule

// File: rtl/cnv_ctrl_reg.sv
module cnv_ctrl_reg
  import cnv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          trig_in,
  input  logic          seq_done,
  output logic          en,
  output logic          busy,
  output logic          auto_trig,
  output logic          flag,
  output logic          ie,
  output logic [2:0]    div,
  output logic          seq_start,
  output logic          conv_start,
  output logic          conv_end,
  output logic          flag_set,
  output logic          flag_clr
);
  logic sw_start, hw_start;

  always_comb begin
    sw_start   = wr_en && wdata[B_GO] && wdata[B_EN];
    hw_start   = auto_trig && en && trig_in;
    conv_start = (sw_start || hw_start) && !busy;
    conv_end   = seq_done && busy;
    flag_set   = conv_end;
    flag_clr   = wr_en && wdata[B_FLAG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; auto_trig <= 1'b0; ie <= 1'b0; div <= '0;
      busy <= 1'b0; flag <= 1'b0; seq_start <= 1'b0;
    end else begin
      if (wr_en) begin
        en        <= wdata[B_EN];
        auto_trig <= wdata[B_AUTO];
        ie        <= wdata[B_IE];
        div       <= wdata[2:0];
      end
      if (conv_start)    busy <= 1'b1;
      else if (conv_end) busy <= 1'b0;
      if (flag_set)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      seq_start <= conv_start;
    end
  end
endmodule

// File: rtl/cnv_data_reg.sv
module cnv_data_reg
  import cnv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_end,
  input  logic [RES_W-1:0] result,
  input  logic             lo_rd,
  input  logic             hi_rd,
  input  logic             left_adj,
  output logic [DW-1:0]    lo_byte,
  output logic [DW-1:0]    hi_byte,
  output logic             locked,
  output logic             capture
);
  logic [RES_W-1:0] res_q;

  assign capture = conv_end && !locked && !lo_rd;
  assign lo_byte = fmt_lo(res_q, left_adj);
  assign hi_byte = fmt_hi(res_q, left_adj);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      locked <= 1'b0;
    end else begin
      if (capture)    res_q  <= result;
      if (lo_rd)      locked <= 1'b1;
      else if (hi_rd) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/cnv_regs.sv
module cnv_regs
  import cnv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             trig_in,
  output logic             seq_start,
  input  logic             seq_done,
  input  logic [RES_W-1:0] seq_result,
  output logic [1:0]       ref_sel,
  output logic [3:0]       chan_sel,
  output logic [2:0]       div_sel,
  output logic             conv_en,
  output logic             irq
);
  logic setup_wr, ctrl_wr, lo_rd, hi_rd;
  logic left_adj, busy, auto_trig, flag, ie;
  logic conv_start, conv_end, flag_set, flag_clr, locked, capture;
  logic [DW-1:0] lo_byte, hi_byte;

  assign setup_wr = bus_wr && (bus_addr == A_SETUP);
  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign lo_rd    = bus_rd && (bus_addr == A_LO);
  assign hi_rd    = bus_rd && (bus_addr == A_HI);

  cnv_setup_reg u_setup (
    .clk(clk), .rst_n(rst_n), .wr_en(setup_wr),
    .ref_in(bus_wdata[7:6]), .left_in(bus_wdata[5]), .chan_in(bus_wdata[3:0]),
    .ref_sel(ref_sel), .left_adj(left_adj), .chan_sel(chan_sel)
  );

  cnv_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(bus_wdata),
    .trig_in(trig_in), .seq_done(seq_done),
    .en(conv_en), .busy(busy), .auto_trig(auto_trig), .flag(flag), .ie(ie),
    .div(div_sel), .seq_start(seq_start), .conv_start(conv_start),
    .conv_end(conv_end), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  cnv_data_reg u_data (
    .clk(clk), .rst_n(rst_n), .conv_end(conv_end), .result(seq_result),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .left_adj(left_adj),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .locked(locked), .capture(capture)
  );

  assign irq = ie && flag;

  always_comb begin
    unique case (bus_addr)
      A_SETUP: bus_rdata = {ref_sel, left_adj, 1'b0, chan_sel};
      A_CTRL:  bus_rdata = {conv_en, busy, auto_trig, flag, ie, div_sel};
      A_LO:    bus_rdata = lo_byte;
      default: bus_rdata = hi_byte;
    endcase
  end
endmodule

// File: rtl/cnv_regs_chk.sv
module cnv_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       conv_start,
  input logic       conv_end,
  input logic       flag,
  input logic       ie,
  input logic       irq,
  input logic       seq_start,
  input logic       locked,
  input logic       hi_rd,
  input logic       setup_wr,
  input logic       ctrl_wr,
  input logic [7:0] wdata,
  input logic [7:0] hi_byte,
  input logic       trig_in
);
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> seq_start && busy);
  a_r3_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> !busy);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> flag);
  a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(ctrl_wr && wdata[4]) |=> flag);
  a_r5_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end && ie && !ctrl_wr |=> irq);
  a_r6_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ctrl_wr && !wdata[7] && !trig_in |=> !busy);
  a_r9_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !hi_rd && !setup_wr |=> $stable(hi_byte));
endmodule

bind cnv_regs cnv_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .conv_start(conv_start),
  .conv_end(conv_end), .flag(flag), .ie(ie), .irq(irq), .seq_start(seq_start),
  .locked(locked), .hi_rd(hi_rd), .setup_wr(setup_wr), .ctrl_wr(ctrl_wr),
  .wdata(bus_wdata), .hi_byte(hi_byte), .trig_in(trig_in)
);

// File: tb/cnv_regs_tb.sv
module cnv_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       trig_in = 1'b0, seq_done = 1'b0;
  logic [9:0] seq_result = '0;
  logic       seq_start, conv_en, irq;
  logic [1:0] ref_sel;
  logic [3:0] chan_sel;
  logic [2:0] div_sel;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cnv_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .seq_start(seq_start), .seq_done(seq_done),
    .seq_result(seq_result), .ref_sel(ref_sel), .chan_sel(chan_sel),
    .div_sel(div_sel), .conv_en(conv_en), .irq(irq)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: reads sampled mid-cycle
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic push_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    push_rd(a, e, t);
    step();
    bus_rd = 1'b0;
  endtask

  task automatic finish_conv(input logic [9:0] r);
    step();
    seq_result = r; seq_done = 1'b1;
    step();
    seq_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd(0, 8'h00, "R1 setup");
    rd(1, 8'h00, "R1 ctrl");
    rd(2, 8'h00, "R1 lo");
    rd(3, 8'h00, "R1 hi");
    chk({7'd0, irq}, 8'h00, "R1 irq");
    chk({7'd0, seq_start}, 8'h00, "R1 seq_start");

    // R2 setup fields
    wr(0, 8'hFF);
    rd(0, 8'hEF, "R2 readback bit4 zero");
    chk({6'd0, ref_sel}, 8'h03, "R2 ref_sel");
    chk({4'd0, chan_sel}, 8'h0F, "R2 chan_sel");
    wr(0, 8'h40);
    rd(0, 8'h40, "R2 supply ch0 right");

    // R6 start with enable low
    wr(1, 8'h47);
    chk({7'd0, seq_start}, 8'h00, "R6 no pulse");
    rd(1, 8'h07, "R6 not started");

    // R3 start and self-clear
    wr(1, 8'hC7);
    chk({7'd0, seq_start}, 8'h01, "R3 pulse");
    rd(1, 8'hC7, "R3 start reads 1");
    chk({7'd0, seq_start}, 8'h00, "R3 pulse one cycle");
    wr(1, 8'h87);
    rd(1, 8'hC7, "R6 start=0 keeps running");
    finish_conv(10'h2A5);
    rd(1, 8'h97, "R3 R4 start cleared flag set");

    // R7 right alignment
    rd(2, 8'hA5, "R7 lo");
    rd(3, 8'h02, "R7 hi");

    // R4 flag clear semantics
    wr(1, 8'h87);
    rd(1, 8'h97, "R4 write0 keeps flag");
    wr(1, 8'h97);
    rd(1, 8'h87, "R4 write1 clears flag");

    // R8 left alignment reformats stored result
    wr(0, 8'h60);
    rd(2, 8'h40, "R8 lo");
    rd(3, 8'hA9, "R8 hi");
    wr(0, 8'h40);

    // R5 interrupt
    wr(1, 8'hCF);
    chk({7'd0, irq}, 8'h00, "R5 irq idle");
    finish_conv(10'h155);
    chk({7'd0, irq}, 8'h01, "R5 irq raised");
    rd(1, 8'h9F, "R5 ctrl");
    wr(1, 8'h9F);
    chk({7'd0, irq}, 8'h00, "R5 irq cleared");

    // R9 lock
    rd(2, 8'h55, "R9 lo locks");
    wr(1, 8'hC7);
    finish_conv(10'h3FF);
    rd(3, 8'h01, "R9 hi frozen");
    rd(1, 8'h97, "R9 flag still set");
    rd(2, 8'h55, "R9 result discarded lo");
    rd(3, 8'h01, "R9 result discarded hi");
    wr(1, 8'h97);
    wr(1, 8'hC7);
    finish_conv(10'h3FF);
    rd(2, 8'hFF, "R9 unlocked lo");
    rd(3, 8'h03, "R9 unlocked hi");

    // R10 done collides with flag clear
    wr(1, 8'h97);
    wr(1, 8'hC7);
    step();
    seq_result = 10'h001; seq_done = 1'b1;
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h97;
    step();
    seq_done = 1'b0; bus_wr = 1'b0;
    rd(1, 8'h97, "R10 set wins");
    wr(1, 8'h97);
    rd(1, 8'h87, "R10 cleared after");

    // R12 done collides with low read
    wr(1, 8'hC7);
    step();
    seq_result = 10'h123; seq_done = 1'b1;
    push_rd(2, 8'h01, "R12 lo during done");
    step();
    seq_done = 1'b0; bus_rd = 1'b0;
    rd(3, 8'h00, "R12 hi consistent");
    rd(2, 8'h01, "R12 new result dropped lo");
    rd(3, 8'h00, "R12 new result dropped hi");
    rd(1, 8'h97, "R12 flag set");
    wr(1, 8'h97);

    // R11 trigger
    wr(1, 8'h87);
    trig_in = 1'b1; step(); trig_in = 1'b0;
    chk({7'd0, seq_start}, 8'h00, "R11 trig ignored");
    rd(1, 8'h87, "R11 idle");
    wr(1, 8'hA7);
    trig_in = 1'b1; step(); trig_in = 1'b0;
    chk({7'd0, seq_start}, 8'h01, "R11 trig start");
    rd(1, 8'hE7, "R11 busy");
    finish_conv(10'h0F0);
    rd(2, 8'hF0, "R11 lo");
    rd(3, 8'h00, "R11 hi");

    repeat (2) step();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule